// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block holds an 8-bit event timer and a watchdog. The two share a single programmable prescaler. A set of configuration inputs decides four things: which of the two owns the prescaler, the division exponent, whether the timer counts instruction-cycle ticks or transitions on an external pin, and which transition of that pin is counted. The timer can be loaded through a write port. It raises a one-cycle overflow pulse when it wraps. The prescaler's running count is brought out so that it can be read back.

The watchdog counts a free-running tick from a slow oscillator. Its base period is 2^WDT_W ticks. When it owns the prescaler, it stretches that period into two request streams. The reset request repeats every 2^rate base periods. The interrupt request repeats every 2^(rate+1) base periods, and the first one comes half an interrupt period after a clear or a reset. The timer side divides by 2^(rate+1) when it owns the prescaler. A watchdog clear strobe restarts the watchdog.

Top module: `twp_timer_wdt`

## Requirements
- R1: After reset, tmr_value, psc_count, tmr_ovf, wdt_rst_req and wdt_irq_req are all zero.
- R2: With cfg_wdt_own=1 and cfg_ext_src=0, tmr_value increments by one on the clock edge that samples cyc_tick high, and ext_pin has no effect.
- R3: With cfg_wdt_own=0, each timer event advances psc_count by one (modulo 256), and tmr_value increments once every 2^(cfg_rate+1) events.
- R4: With cfg_ext_src=1, timer events are transitions of ext_pin after two synchronising flops. cfg_fall_edge=0 counts low-to-high transitions and cfg_fall_edge=1 counts high-to-low transitions. A level first sampled at edge k produces its event at edge k+2. cyc_tick is ignored in this mode.
- R5: tmr_ovf is high for exactly the one cycle after an increment takes tmr_value from 255 to 0.
- R6: tmr_wr loads tmr_wdata on the next edge and wins over a simultaneous increment. It clears psc_count when cfg_wdt_own=0 and leaves psc_count unchanged when cfg_wdt_own=1.
- R7: The watchdog base period is 2^WDT_W wdt_tick pulses. With cfg_wdt_own=0, wdt_rst_req and wdt_irq_req both pulse at the end of every base period.
- R8: With cfg_wdt_own=1, wdt_rst_req pulses at the end of every 2^cfg_rate base periods, counted from the last clear or reset.
- R9: With cfg_wdt_own=1, wdt_irq_req first pulses after 2^cfg_rate base periods and then every 2^(cfg_rate+1) base periods.
- R10: wdt_clr restarts the base period and suppresses any request on that edge. It clears psc_count only when cfg_wdt_own=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | Instruction-cycle tick, used as the internal timer source |
| ext_pin | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Watchdog oscillator tick |
| cfg_wdt_own | input | 1 | 1: watchdog owns the prescaler; 0: timer owns it |
| cfg_ext_src | input | 1 | 1: timer counts ext_pin transitions; 0: it counts cyc_tick |
| cfg_fall_edge | input | 1 | 1: count falling transitions; 0: count rising transitions |
| cfg_rate | input | RATE_W | Division exponent selector |
| tmr_wr | input | 1 | Timer load strobe |
| tmr_wdata | input | TMR_W | Timer load value |
| wdt_clr | input | 1 | Watchdog clear strobe |
| tmr_value | output | TMR_W | Current timer count |
| tmr_ovf | output | 1 | Timer wrap pulse |
| wdt_rst_req | output | 1 | Watchdog reset request pulse |
| wdt_irq_req | output | 1 | Watchdog interrupt request pulse |
| psc_count | output | 2**RATE_W | Prescaler count readback |

## Verification
The hardest case to reach is the half-period first interrupt. It only shows after several full watchdog base periods pass with the prescaler owned by the watchdog and no stray clear in between. The stimulus issues a clear and then holds wdt_tick high at a chosen exponent. It counts clock edges to the first and second reset pulses and interrupt pulses, and checks them against 2^rate and 2^(rate+1) base periods. A long pseudo-random phase then changes ownership and exponent while counting is in progress, and clears and timer writes land on arbitrary prescaler values. A cycle-by-cycle model follows every one of these cases.

// File: rtl/twp_pkg.sv
package twp_pkg;
    localparam int unsigned TWP_RATE_W_DEF = 3;
    localparam int unsigned TWP_TMR_W_DEF  = 8;
    localparam int unsigned TWP_WDT_W_DEF  = 6;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } twp_sync_t;

    typedef struct packed {
        logic ovf;
        logic wrst;
        logic wirq;
    } twp_pulse_t;
endpackage

// File: rtl/twp_pin_edge.sv
module twp_pin_edge
    import twp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    twp_sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = pin_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
        if (fall_sel_i) begin
            edge_o = sync_q.prev & ~sync_q.s2;
        end else begin
            edge_o = ~sync_q.prev & sync_q.s2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end
endmodule

// File: rtl/twp_wdt_base.sv
module twp_wdt_base #(
    parameter int unsigned WDT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic ovf_o
);
    logic [WDT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        ovf_o = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + {{(WDT_W-1){1'b0}}, 1'b1};
            ovf_o = &cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/twp_rate_match.sv
module twp_rate_match #(
    parameter  int unsigned RATE_W = 3,
    localparam int unsigned PSC_W  = 1 << RATE_W
) (
    input  logic [PSC_W-1:0]  psc_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tmr_term_o,
    output logic              wrst_term_o,
    output logic              wirq_term_o
);
    // pre[i] is high when prescaler bits below i are all ones
    logic [PSC_W-1:0] pre;

    assign pre[0] = 1'b1;
    for (genvar i = 1; i < PSC_W; i++) begin : g_prefix
        assign pre[i] = pre[i-1] & psc_i[i-1];
    end

    always_comb begin
        wrst_term_o = pre[rate_i];
        tmr_term_o  = pre[rate_i] & psc_i[rate_i];
        wirq_term_o = pre[rate_i] & ~psc_i[rate_i];
    end
endmodule

// File: rtl/twp_timer_wdt.sv
module twp_timer_wdt
    import twp_pkg::*;
#(
    parameter  int unsigned RATE_W = TWP_RATE_W_DEF,
    parameter  int unsigned TMR_W  = TWP_TMR_W_DEF,
    parameter  int unsigned WDT_W  = TWP_WDT_W_DEF,
    localparam int unsigned PSC_W  = 1 << RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              ext_pin,
    input  logic              wdt_tick,
    input  logic              cfg_wdt_own,
    input  logic              cfg_ext_src,
    input  logic              cfg_fall_edge,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              tmr_wr,
    input  logic [TMR_W-1:0]  tmr_wdata,
    input  logic              wdt_clr,
    output logic [TMR_W-1:0]  tmr_value,
    output logic              tmr_ovf,
    output logic              wdt_rst_req,
    output logic              wdt_irq_req,
    output logic [PSC_W-1:0]  psc_count
);
    localparam logic [TMR_W-1:0] TMR_ONE = {{(TMR_W-1){1'b0}}, 1'b1};
    localparam logic [PSC_W-1:0] PSC_ONE = {{(PSC_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [PSC_W-1:0] psc;
        twp_pulse_t       pulse;
    } state_t;

    state_t st_d, st_q;

    logic pin_evt, wdt_ovf;
    logic tmr_term, wrst_term, wirq_term;
    logic tmr_evt, psc_evt, tmr_inc;

    twp_pin_edge u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin),
        .fall_sel_i (cfg_fall_edge),
        .edge_o     (pin_evt)
    );

    twp_wdt_base #(.WDT_W(WDT_W)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (wdt_tick),
        .clr_i  (wdt_clr),
        .ovf_o  (wdt_ovf)
    );

    twp_rate_match #(.RATE_W(RATE_W)) u_match (
        .psc_i       (st_q.psc),
        .rate_i      (cfg_rate),
        .tmr_term_o  (tmr_term),
        .wrst_term_o (wrst_term),
        .wirq_term_o (wirq_term)
    );

    always_comb begin
        tmr_evt = cfg_ext_src ? pin_evt : cyc_tick;
        psc_evt = cfg_wdt_own ? wdt_ovf : tmr_evt;
        tmr_inc = cfg_wdt_own ? tmr_evt : (tmr_evt & tmr_term);

        st_d       = st_q;
        st_d.pulse = '0;

        // timer: a load wins over a count
        if (tmr_wr) begin
            st_d.tmr = tmr_wdata;
        end else if (tmr_inc) begin
            st_d.tmr       = st_q.tmr + TMR_ONE;
            st_d.pulse.ovf = &st_q.tmr;
        end

        // prescaler: cleared by the owner's restart strobe
        if (!cfg_wdt_own && tmr_wr) begin
            st_d.psc = '0;
        end else if (cfg_wdt_own && wdt_clr) begin
            st_d.psc = '0;
        end else if (psc_evt) begin
            st_d.psc = st_q.psc + PSC_ONE;
        end

        st_d.pulse.wrst = wdt_ovf & (~cfg_wdt_own | wrst_term);
        st_d.pulse.wirq = wdt_ovf & (~cfg_wdt_own | wirq_term);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_value   = st_q.tmr;
    assign tmr_ovf     = st_q.pulse.ovf;
    assign wdt_rst_req = st_q.pulse.wrst;
    assign wdt_irq_req = st_q.pulse.wirq;
    assign psc_count   = st_q.psc;
endmodule

// File: rtl/twp_timer_wdt_chk.sv
module twp_timer_wdt_chk #(
    parameter  int unsigned RATE_W = 3,
    parameter  int unsigned TMR_W  = 8,
    localparam int unsigned PSC_W  = 1 << RATE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tmr_wr,
    input logic [TMR_W-1:0]  tmr_wdata,
    input logic              wdt_clr,
    input logic              cfg_wdt_own,
    input logic [TMR_W-1:0]  tmr_value,
    input logic              tmr_ovf,
    input logic              wdt_rst_req,
    input logic              wdt_irq_req,
    input logic [PSC_W-1:0]  psc_count
);
    localparam logic [TMR_W-1:0] ONE = {{(TMR_W-1){1'b0}}, 1'b1};

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_wr |=> (tmr_value == $past(tmr_value)) || (tmr_value == $past(tmr_value) + ONE));

    p_ovf_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |-> tmr_value == '0);

    p_ovf_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> !tmr_ovf);

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> tmr_value == $past(tmr_wdata));

    p_clr_psc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr && cfg_wdt_own && !tmr_wr) |=> psc_count == '0);

    p_clr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_rst_req && !wdt_irq_req);

    p_irq_with_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq_req |-> wdt_rst_req);
endmodule

bind twp_timer_wdt twp_timer_wdt_chk #(.RATE_W(RATE_W), .TMR_W(TMR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_wr      (tmr_wr),
    .tmr_wdata   (tmr_wdata),
    .wdt_clr     (wdt_clr),
    .cfg_wdt_own (cfg_wdt_own),
    .tmr_value   (tmr_value),
    .tmr_ovf     (tmr_ovf),
    .wdt_rst_req (wdt_rst_req),
    .wdt_irq_req (wdt_irq_req),
    .psc_count   (psc_count)
);

// File: tb/tb_twp_timer_wdt.sv
module tb_twp_timer_wdt;
    localparam int CLK_PERIOD = 10;
    localparam int RATE_W = 3;
    localparam int TMR_W  = 8;
    localparam int WDT_W  = 6;
    localparam int PSC_W  = 1 << RATE_W;
    localparam int WB     = 1 << WDT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_tick = 0, ext_pin = 0, wdt_tick = 0;
    logic cfg_wdt_own = 0, cfg_ext_src = 0, cfg_fall_edge = 0;
    logic [RATE_W-1:0] cfg_rate = '0;
    logic tmr_wr = 0, wdt_clr = 0;
    logic [TMR_W-1:0] tmr_wdata = '0;
    logic [TMR_W-1:0] tmr_value;
    logic tmr_ovf, wdt_rst_req, wdt_irq_req;
    logic [PSC_W-1:0] psc_count;

    int checks = 0;
    int errors = 0;
    bit checking = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    twp_timer_wdt #(.RATE_W(RATE_W), .TMR_W(TMR_W), .WDT_W(WDT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
        .wdt_tick(wdt_tick), .cfg_wdt_own(cfg_wdt_own), .cfg_ext_src(cfg_ext_src),
        .cfg_fall_edge(cfg_fall_edge), .cfg_rate(cfg_rate), .tmr_wr(tmr_wr),
        .tmr_wdata(tmr_wdata), .wdt_clr(wdt_clr), .tmr_value(tmr_value),
        .tmr_ovf(tmr_ovf), .wdt_rst_req(wdt_rst_req), .wdt_irq_req(wdt_irq_req),
        .psc_count(psc_count)
    );

    // behavioural reference model
    int m_tmr, m_psc, m_wb;
    bit m_ovf, m_rst, m_irq, m_s1, m_s2, m_prev;

    always @(posedge clk) begin
        bit evt, wov, tinc, pe;
        int div_t, div_r;
        if (!rst_n) begin
            m_tmr = 0; m_psc = 0; m_wb = 0;
            m_ovf = 0; m_rst = 0; m_irq = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            evt = cfg_ext_src ? (cfg_fall_edge ? (m_prev && !m_s2) : (!m_prev && m_s2)) : cyc_tick;
            wov = wdt_tick && !wdt_clr && (m_wb == WB - 1);
            m_wb = wdt_clr ? 0 : (wdt_tick ? (m_wb + 1) % WB : m_wb);
            div_r = 1 << int'(cfg_rate);
            div_t = 2 << int'(cfg_rate);
            m_ovf = 0; m_rst = 0; m_irq = 0;
            if (wov) begin
                if (!cfg_wdt_own) begin
                    m_rst = 1; m_irq = 1;
                end else begin
                    m_rst = ((m_psc + 1) % div_r) == 0;
                    m_irq = ((m_psc + 1) % div_t) == div_r;
                end
            end
            tinc = cfg_wdt_own ? evt : (evt && ((m_psc + 1) % div_t) == 0);
            pe   = cfg_wdt_own ? wov : evt;
            if (tmr_wr) m_tmr = int'(tmr_wdata);
            else if (tinc) begin
                if (m_tmr == 255) m_ovf = 1;
                m_tmr = (m_tmr + 1) % 256;
            end
            if (!cfg_wdt_own && tmr_wr) m_psc = 0;
            else if (cfg_wdt_own && wdt_clr) m_psc = 0;
            else if (pe) m_psc = (m_psc + 1) % 256;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            check(cur_req, "tmr_value", int'(tmr_value), m_tmr);
            check(cur_req, "psc_count", int'(psc_count), m_psc);
            check(cur_req, "tmr_ovf", int'(tmr_ovf), int'(m_ovf));
            check(cur_req, "wdt_rst_req", int'(wdt_rst_req), int'(m_rst));
            check(cur_req, "wdt_irq_req", int'(wdt_irq_req), int'(m_irq));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_timer(input int v);
        tmr_wr = 1; tmr_wdata = TMR_W'(v);
        step(1);
        tmr_wr = 0;
    endtask

    task automatic wdt_restart();
        wdt_clr = 1;
        step(1);
        wdt_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ovf_seen, r1t, r2t, i1t, i2t, n, psc_keep;
        logic [15:0] lf;
        step(3);
        rst_n = 1;
        step(1);
        // R1: reset state
        check("R1", "tmr_value", int'(tmr_value), 0);
        check("R1", "psc_count", int'(psc_count), 0);
        check("R1", "pulses", int'({tmr_ovf, wdt_rst_req, wdt_irq_req}), 0);
        checking = 1;

        // R2 and R5: direct counting, pin toggling ignored
        cur_req = "R2";
        cfg_wdt_own = 1; cfg_ext_src = 0;
        ovf_seen = 0;
        for (int k = 0; k < 600; k++) begin
            cyc_tick = k[0];
            ext_pin = k[1];
            step(1);
            if (tmr_ovf) ovf_seen++;
        end
        cyc_tick = 0;
        check("R5", "overflow count over 300 ticks", ovf_seen, 1);
        check("R2", "timer after 300 ticks", int'(tmr_value), 300 % 256);

        // R3: timer-owned prescaler division
        cur_req = "R3";
        cfg_wdt_own = 0;
        for (int r = 0; r < 4; r++) begin
            cfg_rate = RATE_W'(r);
            load_timer(0);
            cyc_tick = 1;
            step(40);
            cyc_tick = 0;
            step(1);
            check("R3", "divided timer", int'(tmr_value), 40 >> (r + 1));
            check("R3", "prescaler readback", int'(psc_count), 40);
        end

        // R6: write clears prescaler only when timer owns it
        cur_req = "R6";
        load_timer(77);
        check("R6", "loaded value", int'(tmr_value), 77);
        check("R6", "prescaler cleared", int'(psc_count), 0);
        cfg_wdt_own = 1; wdt_tick = 1;
        step(WB * 3);
        wdt_tick = 0;
        psc_keep = int'(psc_count);
        cyc_tick = 1;
        load_timer(9);
        cyc_tick = 0;
        check("R6", "write wins over increment", int'(tmr_value), 9);
        check("R6", "prescaler kept while watchdog owns", int'(psc_count), psc_keep);

        // R4: external pin, rising then falling
        cur_req = "R4";
        cfg_ext_src = 1; cyc_tick = 1;
        for (int e = 0; e < 2; e++) begin
            cfg_fall_edge = e[0];
            ext_pin = 0;
            step(5);
            load_timer(0);
            for (int t = 0; t < 20; t++) begin
                ext_pin = ~ext_pin;
                step(3);
            end
            step(4);
            check("R4", e ? "falling edges counted" : "rising edges counted", int'(tmr_value), 10);
        end
        cyc_tick = 0; cfg_ext_src = 0; ext_pin = 0;

        // R10: clear with timer-owned prescaler keeps the prescaler
        cur_req = "R10";
        cfg_wdt_own = 0; cfg_rate = 3'd3;
        load_timer(0);
        cyc_tick = 1; step(5); cyc_tick = 0;
        wdt_restart();
        check("R10", "prescaler untouched by clear", int'(psc_count), 5);

        // R7: base period with timer-owned prescaler
        cur_req = "R7";
        wdt_clr = 1; wdt_tick = 1;
        step(1);
        wdt_clr = 0;
        n = 0;
        do begin step(1); n++; end while (!wdt_rst_req && n < 1000);
        check("R7", "base period length", n, WB);
        check("R7", "irq with reset", int'(wdt_irq_req), 1);

        // R8, R9: watchdog-owned prescaler, rate 2
        cur_req = "R9";
        cfg_wdt_own = 1; cfg_rate = 3'd2;
        wdt_clr = 1;
        step(1);
        wdt_clr = 0;
        check("R10", "prescaler cleared by clear", int'(psc_count), 0);
        r1t = 0; r2t = 0; i1t = 0; i2t = 0;
        for (int c = 1; c <= 800; c++) begin
            step(1);
            if (wdt_rst_req) begin if (r1t == 0) r1t = c; else if (r2t == 0) r2t = c; end
            if (wdt_irq_req) begin if (i1t == 0) i1t = c; else if (i2t == 0) i2t = c; end
        end
        check("R8", "first reset request", r1t, 4 * WB);
        check("R8", "second reset request", r2t, 8 * WB);
        check("R9", "first irq at half period", i1t, 4 * WB);
        check("R9", "second irq full period later", i2t, 12 * WB);
        wdt_tick = 0;

        // mixed pseudo-random traffic against the model
        cur_req = "R3";
        lf = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc_tick = lf[0];
            ext_pin = lf[3] & lf[5];
            wdt_tick = lf[1] | lf[7];
            tmr_wr = (lf[11:6] == 6'h15);
            tmr_wdata = lf[15:8];
            wdt_clr = (lf[12:4] == 9'h0AB);
            if (lf[9:2] == 8'h3C) begin
                cfg_wdt_own = lf[13]; cfg_ext_src = lf[14];
                cfg_fall_edge = lf[15]; cfg_rate = lf[10:8];
            end
            step(1);
        end
        tmr_wr = 0; wdt_clr = 0;
        step(2);
        checking = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule